// File: doc/BRIEF.md
# Ring Register Access Node

This block is one stop on a ring of register nodes that links a bus master to several datapath sub-modules. Every message on the ring carries a request flag, an acknowledge bit, a read/write bit, a 23-bit address, 32-bit data and a 2-bit source tag. The node owns a small window of the address space. The window holds software registers, which the ring can write and read and which drive the attached sub-module, and hardware registers, which are read-only views of status signals from that sub-module. Traffic outside the window, and traffic that another node has already acknowledged, moves on one clock later with every field unchanged.

A request inside the window is served over `ACC_LAT` cycles. A two-state machine controls this. In `ST_IDLE` the node looks at the oldest waiting message. If that message is an unacknowledged hit, the *start* transition moves the node to `ST_ACCESS`. Otherwise the message is forwarded. In `ST_ACCESS` the *hold* transition keeps the state while a countdown runs. The *done* transition performs the access, launches the reply with the acknowledge bit set and returns to `ST_IDLE`. While the node is busy, messages that arrive are queued in a small FIFO. They leave in the order they arrived, so nothing is dropped or reordered.

Top module: `ring_reg_node`

## Requirements
- R1: After reset `out_req` is low and every software register reads as zero on `sw_regs_o`. Software register k appears at `sw_regs_o[32k+31:32k]`.
- R2: A request whose address bits above the local index do not equal those bits of `BASE_ADDR` (default 0x000120) leaves the node with every field unchanged. `out_req` rises for one cycle, exactly one clock after the request arrives at an idle node with an empty queue.
- R3: A write (`in_is_read` low) to an in-window index 0..NUM_SW-1 stores the data. The reply comes `ACC_LAT` clocks after arrival with ack high and the request's address, data, read bit and tag. From the reply cycle onward, `sw_regs_o` shows the new value.
- R4: A read (`in_is_read` high) of an in-window index below NUM_SW returns that register's current contents on `out_data`, with ack high.
- R5: A read of in-window index NUM_SW+j returns `hw_status_i[32j+31:32j]` as sampled on the clock edge that launches the reply. This reflects the live status value.
- R6: A write to a hardware index is acknowledged with its own data echoed back, and it changes no software register.
- R7: A request that arrives with ack already high is forwarded unchanged one clock later, even when its address is in the window. No register is touched.
- R8: The source tag of every forwarded message and every reply equals the tag of the request it came from.
- R9: Messages that arrive while a reply is pending are held in a FIFO of `FIFO_DEPTH` entries. They are emitted in arrival order, one per `out_req` pulse, and none is lost.
- R10: The node never emits an in-window message with ack low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | One-cycle message valid from the upstream node |
| in_ack | input | 1 | Message already serviced |
| in_is_read | input | 1 | High for read, low for write |
| in_addr | input | 23 | Register address |
| in_data | input | 32 | Write data or earlier read data |
| in_src | input | 2 | Requester tag |
| out_req | output | 1 | One-cycle message valid to the downstream node |
| out_ack | output | 1 | Message serviced |
| out_is_read | output | 1 | Read/write bit carried through |
| out_addr | output | 23 | Address carried through |
| out_data | output | 32 | Read data or data carried through |
| out_src | output | 2 | Requester tag carried through |
| hw_status_i | input | NUM_HW*32 | Status words from the sub-module |
| sw_regs_o | output | NUM_SW*32 | Software register contents to the sub-module |

## Verification
If the state machine were stuck in `ST_ACCESS`, or left it early, the reply would arrive at the wrong latency or never arrive. Traffic behind it would then pile up, and this shows within `ACC_LAT` plus a few clocks. A corrupt queue pointer makes later messages come out duplicated, missing or out of order at the ring output. This is visible on the first burst that overlaps a pending access. A software register that changes at the wrong time appears on `sw_regs_o`, or on the next read reply, one clock after the faulty edge.

// File: rtl/ring_node_pkg.sv
`timescale 1ns/1ps
package ring_node_pkg;

    localparam int ADDR_W = 23;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 2;

    typedef struct packed {
        logic              ack;
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SRC_W-1:0]  src;
    } ring_msg_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } node_state_t;

endpackage

// File: rtl/ring_msg_fifo.sv
`timescale 1ns/1ps
module ring_msg_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop); // R9
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/ring_reg_bank.sv
`timescale 1ns/1ps
module ring_reg_bank #(
    parameter int NUM_SW = 4,
    parameter int NUM_HW = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_HW*DATA_W-1:0] hw_status,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_SW*DATA_W-1:0] sw_flat
);

    logic [DATA_W-1:0] sw_q [NUM_SW];

    for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_q[g] <= '0;
            end else if (wr_en && idx == IDX_W'(g)) begin
                sw_q[g] <= wr_data;
            end
        end
        assign sw_flat[g*DATA_W +: DATA_W] = sw_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SW; i++) begin
            if (idx == IDX_W'(i)) rd_data = sw_q[i];
        end
        for (int j = 0; j < NUM_HW; j++) begin
            if (idx == IDX_W'(NUM_SW + j)) rd_data = hw_status[j*DATA_W +: DATA_W];
        end
    end

    AST_SW_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_en) && $past(idx) < IDX_W'(NUM_SW)) |-> $stable(sw_flat)); // R6

endmodule

// File: rtl/ring_reg_node.sv
`timescale 1ns/1ps
module ring_reg_node
    import ring_node_pkg::*;
#(
    parameter logic [22:0] BASE_ADDR  = 23'h000120,
    parameter int          NUM_SW     = 4,
    parameter int          NUM_HW     = 4,
    parameter int          FIFO_DEPTH = 4,
    parameter int          ACC_LAT    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_req,
    input  logic                     in_ack,
    input  logic                     in_is_read,
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [SRC_W-1:0]         in_src,
    output logic                     out_req,
    output logic                     out_ack,
    output logic                     out_is_read,
    output logic [ADDR_W-1:0]        out_addr,
    output logic [DATA_W-1:0]        out_data,
    output logic [SRC_W-1:0]         out_src,
    input  logic [NUM_HW*DATA_W-1:0] hw_status_i,
    output logic [NUM_SW*DATA_W-1:0] sw_regs_o
);

    localparam int SLOTS = NUM_SW + NUM_HW;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1;
    localparam int MSG_W = $bits(ring_msg_t);

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W];
    endfunction

    node_state_t      state_q, state_d;
    logic [CNT_W-1:0] wait_cnt;
    ring_msg_t        in_msg, sel_msg, head_msg, cur_q;
    logic [MSG_W-1:0] head_bits;
    logic             fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic             idle, work_avail, sel_hit, finish;
    logic [DATA_W-1:0] bank_rd;

    assign in_msg = '{ack: in_ack, is_read: in_is_read, addr: in_addr,
                      data: in_data, src: in_src};
    assign head_msg   = head_bits;
    assign idle       = (state_q == ST_IDLE);
    assign sel_msg    = fifo_empty ? in_msg : head_msg;
    assign work_avail = idle && (!fifo_empty || in_req);
    assign sel_hit    = !sel_msg.ack && in_window(sel_msg.addr);
    assign fifo_push  = in_req && !(idle && fifo_empty);
    assign fifo_pop   = idle && !fifo_empty;
    assign finish     = (state_q == ST_ACCESS) && (wait_cnt == '0);

    ring_msg_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (MSG_W)
    ) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (in_msg),
        .dout  (head_bits),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ring_reg_bank #(
        .NUM_SW (NUM_SW),
        .NUM_HW (NUM_HW),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (finish && !cur_q.is_read),
        .idx       (cur_q.addr[IDX_W-1:0]),
        .wr_data   (cur_q.data),
        .hw_status (hw_status_i),
        .rd_data   (bank_rd),
        .sw_flat   (sw_regs_o)
    );

    // next-state: start / hold / done
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = (work_avail && sel_hit) ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_d = (wait_cnt == '0) ? ST_IDLE : ST_ACCESS;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured request and access countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            cur_q    <= '0;
        end else if (idle && work_avail && sel_hit) begin
            wait_cnt <= CNT_W'(ACC_LAT - 2);
            cur_q    <= sel_msg;
        end else if (state_q == ST_ACCESS && wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // ring output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_req     <= 1'b0;
            out_ack     <= 1'b0;
            out_is_read <= 1'b0;
            out_addr    <= '0;
            out_data    <= '0;
            out_src     <= '0;
        end else begin
            out_req <= 1'b0;
            if (finish) begin
                out_req     <= 1'b1;
                out_ack     <= 1'b1;
                out_is_read <= cur_q.is_read;
                out_addr    <= cur_q.addr;
                out_data    <= cur_q.is_read ? bank_rd : cur_q.data;
                out_src     <= cur_q.src;
            end else if (work_avail && !sel_hit) begin
                out_req     <= 1'b1;
                out_ack     <= sel_msg.ack;
                out_is_read <= sel_msg.is_read;
                out_addr    <= sel_msg.addr;
                out_data    <= sel_msg.data;
                out_src     <= sel_msg.src;
            end
        end
    end

    AST_PASS_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && idle && fifo_empty && (in_ack || !in_window(in_addr)))
        |=> (out_req && out_addr == $past(in_addr) && out_data == $past(in_data)
             && out_ack == $past(in_ack) && out_is_read == $past(in_is_read))); // R2
    AST_TAG_ON_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && idle && fifo_empty && (in_ack || !in_window(in_addr)))
        |=> out_src == $past(in_src)); // R8
    AST_REPLY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (out_req && out_ack)); // R3
    AST_UNACKED_IS_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |-> !in_window(out_addr)); // R10
    AST_QUEUE_DRAINS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !fifo_empty) |=> out_req || state_q == ST_ACCESS); // R9

endmodule

// File: tb/ring_reg_node_test.sv
`timescale 1ns/1ps
module ring_reg_node_test;

    localparam logic [22:0] BASE = 23'h000120;
    localparam int NSW = 4;
    localparam int NHW = 4;
    localparam int LAT = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_req = 1'b0, in_ack = 1'b0, in_is_read = 1'b0;
    logic [22:0]          in_addr = '0;
    logic [31:0]          in_data = '0;
    logic [1:0]           in_src = '0;
    logic                 out_req, out_ack, out_is_read;
    logic [22:0]          out_addr;
    logic [31:0]          out_data;
    logic [1:0]           out_src;
    logic [NHW*32-1:0]    hw_status = '0;
    logic [NSW*32-1:0]    sw_regs;

    int n_chk = 0, n_fail = 0, cyc = 0, n_obs = 0;
    logic [58:0] obs_msg [512];
    int          obs_cyc [512];
    logic [31:0] sw_model [NSW];
    logic [31:0] hw_seed = '0;

    ring_reg_node #(.BASE_ADDR(BASE), .NUM_SW(NSW), .NUM_HW(NHW),
                    .FIFO_DEPTH(4), .ACC_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_req(in_req), .in_ack(in_ack), .in_is_read(in_is_read),
        .in_addr(in_addr), .in_data(in_data), .in_src(in_src),
        .out_req(out_req), .out_ack(out_ack), .out_is_read(out_is_read),
        .out_addr(out_addr), .out_data(out_data), .out_src(out_src),
        .hw_status_i(hw_status), .sw_regs_o(sw_regs));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_req && n_obs < 512) begin
            obs_msg[n_obs] = {out_ack, out_is_read, out_addr, out_data, out_src};
            obs_cyc[n_obs] = cyc;
            n_obs = n_obs + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] hw_val(input int j);
        return hw_seed + 32'(j) * 32'h01010101;
    endfunction

    task automatic set_hw(input logic [31:0] seed);
        hw_seed = seed;
        for (int j = 0; j < NHW; j++) hw_status[j*32 +: 32] = hw_val(j);
    endtask

    task automatic model(input logic rd, input logic ack, input logic [22:0] addr,
                         input logic [31:0] data, input logic [1:0] src,
                         output logic [58:0] e, output int lat);
        int idx;
        logic [31:0] d;
        if (ack || addr[22:3] != BASE[22:3]) begin
            e = {ack, rd, addr, data, src};
            lat = 1;
        end else begin
            idx = int'(addr[2:0]);
            d = data;
            if (rd) d = (idx < NSW) ? sw_model[idx] : hw_val(idx - NSW);
            else if (idx < NSW) sw_model[idx] = data;
            e = {1'b1, rd, addr, d, src};
            lat = LAT;
        end
    endtask

    task automatic single(input string tag, input logic rd, input logic ack,
                          input logic [22:0] addr, input logic [31:0] data,
                          input logic [1:0] src);
        logic [58:0] e;
        int lat, base, t0;
        model(rd, ack, addr, data, src, e, lat);
        base = n_obs;
        @(negedge clk);
        in_req = 1'b1; in_ack = ack; in_is_read = rd;
        in_addr = addr; in_data = data; in_src = src;
        t0 = cyc;
        @(negedge clk);
        in_req = 1'b0; in_ack = 1'b0; in_is_read = 1'b0;
        in_addr = '0; in_data = '0; in_src = '0;
        repeat (LAT + 3) @(negedge clk);
        chk({tag, " count"}, 64'(n_obs - base), 64'd1);
        chk({tag, " fields"}, 64'(obs_msg[base]), 64'(e));
        chk({tag, " latency"}, 64'(obs_cyc[base] - t0), 64'(lat));
    endtask

    function automatic logic [NSW*32-1:0] sw_flat_model();
        logic [NSW*32-1:0] v;
        for (int k = 0; k < NSW; k++) v[k*32 +: 32] = sw_model[k];
        return v;
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL R9 watchdog actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [58:0] bexp [8];
        logic        b_rd [8], b_ack [8];
        logic [22:0] b_addr [8];
        logic [31:0] b_data [8];
        logic [1:0]  b_src [8];
        int          bl, base, bad;

        for (int k = 0; k < NSW; k++) sw_model[k] = '0;
        set_hw(32'hC0DE0000);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_req after reset", 64'(out_req), 64'd0);
        chk("R1 sw regs after reset", 64'(sw_regs), 64'(sw_flat_model()));

        // writes to every in-window index: R3 for software, R6 for hardware, R8 tags
        for (int i = 0; i < NSW + NHW; i++) begin
            single(i < NSW ? "R3 R8 write sw" : "R6 R8 write hw", 1'b0, 1'b0,
                   BASE | 23'(i), 32'h5A000000 ^ (32'(i) * 32'h00110011), 2'(i));
        end
        chk("R3 R6 sw regs after writes", 64'(sw_regs), 64'(sw_flat_model()));

        // reads of every in-window index: R4 software, R5 hardware
        for (int i = 0; i < NSW + NHW; i++) begin
            single(i < NSW ? "R4 read sw" : "R5 read hw", 1'b1, 1'b0,
                   BASE | 23'(i), 32'hFFFF0000, 2'(3 - (i % 4)));
        end

        // live hardware value after status change
        @(negedge clk);
        set_hw(32'h13572468);
        for (int j = 0; j < NHW; j++) begin
            single("R5 read hw updated", 1'b1, 1'b0, BASE | 23'(NSW + j), 32'h0, 2'(j));
        end

        // out-of-window: flip each address bit above the index
        for (int b = 3; b < 23; b++) begin
            single("R2 R8 R10 forward", 1'(b % 2), 1'b0,
                   (BASE ^ (23'd1 << b)) | 23'(b % 8), 32'(b) * 32'h0F0F0101, 2'(b));
        end

        // already acknowledged, in window: write must not touch anything
        single("R7 acked forward", 1'b0, 1'b1, BASE | 23'd2, 32'hDEADBEEF, 2'd1);
        chk("R7 sw regs unchanged", 64'(sw_regs), 64'(sw_flat_model()));
        single("R7 read after acked write", 1'b1, 1'b0, BASE | 23'd2, 32'h0, 2'd2);

        // back-to-back burst overlapping pending accesses
        b_rd = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
        b_ack = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
        b_addr = '{BASE | 23'd1, BASE | 23'd5, 23'h7FFF00, BASE | 23'd1,
                   23'h000400, BASE | 23'd6, BASE | 23'd2, 23'h000008};
        for (int i = 0; i < 8; i++) begin
            b_data[i] = 32'hA0000000 + 32'(i) * 32'h00001001;
            b_src[i] = 2'(i + 1);
            model(b_rd[i], b_ack[i], b_addr[i], b_data[i], b_src[i], bexp[i], bl);
        end
        base = n_obs;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_req = 1'b1; in_ack = b_ack[i]; in_is_read = b_rd[i];
            in_addr = b_addr[i]; in_data = b_data[i]; in_src = b_src[i];
        end
        @(negedge clk);
        in_req = 1'b0; in_ack = 1'b0;
        repeat (25) @(negedge clk);
        chk("R9 burst count", 64'(n_obs - base), 64'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R9 R8 burst order", 64'(obs_msg[base + i]), 64'(bexp[i]));
        end
        chk("R9 sw regs after burst", 64'(sw_regs), 64'(sw_flat_model()));

        bad = 0;
        for (int i = 0; i < n_obs; i++) begin
            if (!obs_msg[i][58] && obs_msg[i][56:37] == BASE[22:3]) bad++;
        end
        chk("R10 unacked in-window outputs", 64'(bad), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule